// File: doc/BRIEF.md
# Multicycle Processor Sequencing Controller with Exception Entry

This block is the hardwired control unit of a small multicycle load/store processor. A 4-bit state register moves through a fixed set of steps for each instruction. Each state is decoded into the enables and selects that drive the datapath. These cover PC, IR and register-file writes, memory read and write, the memory address source, the ALU operand sources and function, and the PC source. Only the opcode of the instruction held in the IR and the ALU overflow flag steer the sequence.

Two exception entries are built in. An opcode that the block does not recognise at decode time, or an overflow reported while an R-type result is written, diverts the sequence. The block then records a one-bit cause, stores PC minus 4 into the exception PC (so it points back at the faulting instruction), and loads the PC with the fixed handler vector. It then resumes at instruction fetch. The datapath, the memory and the ALU are outside the block.

Top module: `mc_ctrl_top`

## Requirements
- R1: While rst_ni is low the state is 0 (fetch) and the outputs carry the fetch control set. After release the state stays 0 for two more rising edges, because of the reset synchroniser.
- R2: State 0 asserts pc_we_o, ir_we_o and mem_rd_o, with alu_a_reg_o=0 (PC), alu_b_sel_o=001 (constant 4), alu_fn_o=00 (add) and pc_sel_o=00 (ALU result). The next state is always 1.
- R3: State 1 asserts tgt_we_o with alu_a_reg_o=0, alu_b_sel_o=011 (sign-extended immediate shifted left 2) and alu_fn_o=00. It then dispatches on opcode: 100011 (load) and 101011 (store) go to 2, 000000 (R-type) to 6, 000100 (branch-equal) to 8, 000010 (jump) to 9, and 001011 (or-immediate) to 10.
- R4: A load runs through states 0,1,2,3,4, which is five cycles. A store runs through 0,1,2,5. States 2 to 5 use alu_a_reg_o=1, alu_b_sel_o=010 (sign-extended immediate) and add. State 3 adds mem_rd_o and addr_from_alu_o=1. State 4 adds rf_we_o and rf_from_mem_o with rf_dst_rd_o=0. State 5 adds mem_wr_o and addr_from_alu_o=1.
- R5: R-type runs through 6 then 7, with alu_a_reg_o=1, alu_b_sel_o=000 (rt) and alu_fn_o=10 (function field). State 7 adds rf_we_o with rf_dst_rd_o=1. Or-immediate runs through 10 then 11 with alu_a_reg_o=1, alu_b_sel_o=100 (zero-extended immediate) and alu_fn_o=11 (OR). State 11 adds rf_we_o with rf_dst_rd_o=0.
- R6: State 8 (branch-equal) asserts pc_we_cond_o with alu_a_reg_o=1, alu_b_sel_o=000, alu_fn_o=01 (subtract) and pc_sel_o=01 (branch target). State 9 (jump) asserts pc_we_o with pc_sel_o=10 (jump address), so a jump takes three cycles. States 4, 5, 8, 9 and 11 return to 0.
- R7: Any opcode other than the six of R3, seen in state 1, leads to state 12. State 12 asserts cause_we_o with cause_code_o=0.
- R8: In state 7, ovf_i=1 leads to state 13 and ovf_i=0 leads to 0. State 13 asserts cause_we_o with cause_code_o=1. ovf_i has no effect on the state sequence in any other state.
- R9: States 12 and 13 go to 14. State 14 asserts epc_we_o with alu_a_reg_o=0, alu_b_sel_o=001 and alu_fn_o=01, so the ALU forms PC minus 4.
- R10: State 14 goes to 15. State 15 asserts pc_we_o with pc_sel_o=11 (exception vector) and then goes to 0.
- R11: In every state, each control output not named for that state in R2 to R10 is 0. mem_rd_o and mem_wr_o are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| opcode_i | input | 6 | Opcode field of the instruction register |
| ovf_i | input | 1 | ALU overflow flag |
| pc_we_o | output | 1 | Unconditional PC write |
| pc_we_cond_o | output | 1 | PC write when the ALU result is zero |
| ir_we_o | output | 1 | Instruction register write |
| mem_rd_o | output | 1 | Memory read |
| mem_wr_o | output | 1 | Memory write |
| addr_from_alu_o | output | 1 | Memory address from the ALU result (0: from PC) |
| rf_we_o | output | 1 | Register file write |
| rf_dst_rd_o | output | 1 | Write destination rd (0: rt) |
| rf_from_mem_o | output | 1 | Write data from memory (0: ALU) |
| tgt_we_o | output | 1 | Branch target register write |
| alu_a_reg_o | output | 1 | ALU operand A from rs (0: PC) |
| alu_b_sel_o | output | 3 | ALU operand B select |
| alu_fn_o | output | 2 | ALU function |
| pc_sel_o | output | 2 | PC source select |
| cause_we_o | output | 1 | Cause register write |
| cause_code_o | output | 1 | Cause value (0 undefined opcode, 1 overflow) |
| epc_we_o | output | 1 | Exception PC write |
| state_o | output | 4 | Current state number |

## Verification
Two functions fall on the same cycle at the R-type write step. In that state rd is written, and in the same cycle the overflow flag selects the exception branch instead of the return to fetch. The bench provokes this by holding ovf_i high through a whole R-type instruction. The state-7 control set must still show the register write, the next cycle must be state 13 with cause value 1, and the sequence must then go through 14 and 15. A load and an or-immediate run with ovf_i held high must keep their normal sequences.

// File: rtl/mc_ctrl_pkg.sv
package mc_ctrl_pkg;

  localparam int OPC_W = 6;
  localparam int ST_W  = 4;
  localparam int BSEL_W = 3;
  localparam int FN_W   = 2;
  localparam int PSEL_W = 2;

  typedef enum logic [ST_W-1:0] {
    S_FETCH  = 4'd0,
    S_DECODE = 4'd1,
    S_ADDR   = 4'd2,
    S_LDMEM  = 4'd3,
    S_LDWB   = 4'd4,
    S_STMEM  = 4'd5,
    S_REXE   = 4'd6,
    S_RWB    = 4'd7,
    S_BEQ    = 4'd8,
    S_JMP    = 4'd9,
    S_ORIEXE = 4'd10,
    S_ORIWB  = 4'd11,
    S_UNDEF  = 4'd12,
    S_OVF    = 4'd13,
    S_EPC    = 4'd14,
    S_VEC    = 4'd15
  } state_e;

  localparam logic [OPC_W-1:0] OP_LW   = 6'b100011;
  localparam logic [OPC_W-1:0] OP_SW   = 6'b101011;
  localparam logic [OPC_W-1:0] OP_RTY  = 6'b000000;
  localparam logic [OPC_W-1:0] OP_ORI  = 6'b001011;
  localparam logic [OPC_W-1:0] OP_BEQ  = 6'b000100;
  localparam logic [OPC_W-1:0] OP_JMP  = 6'b000010;

  localparam logic [BSEL_W-1:0] B_RT    = 3'b000;
  localparam logic [BSEL_W-1:0] B_FOUR  = 3'b001;
  localparam logic [BSEL_W-1:0] B_SEXT  = 3'b010;
  localparam logic [BSEL_W-1:0] B_SEXT2 = 3'b011;
  localparam logic [BSEL_W-1:0] B_ZEXT  = 3'b100;

  localparam logic [FN_W-1:0] FN_ADD = 2'b00;
  localparam logic [FN_W-1:0] FN_SUB = 2'b01;
  localparam logic [FN_W-1:0] FN_FUN = 2'b10;
  localparam logic [FN_W-1:0] FN_OR  = 2'b11;

  localparam logic [PSEL_W-1:0] P_ALU = 2'b00;
  localparam logic [PSEL_W-1:0] P_TGT = 2'b01;
  localparam logic [PSEL_W-1:0] P_JMP = 2'b10;
  localparam logic [PSEL_W-1:0] P_VEC = 2'b11;

  typedef struct packed {
    logic              pc_we;
    logic              pc_we_cond;
    logic              ir_we;
    logic              mem_rd;
    logic              mem_wr;
    logic              addr_from_alu;
    logic              rf_we;
    logic              rf_dst_rd;
    logic              rf_from_mem;
    logic              tgt_we;
    logic              alu_a_reg;
    logic [BSEL_W-1:0] alu_b_sel;
    logic [FN_W-1:0]   alu_fn;
    logic [PSEL_W-1:0] pc_sel;
    logic              cause_we;
    logic              cause_code;
    logic              epc_we;
  } ctrl_t;

  function automatic logic op_known(input logic [OPC_W-1:0] op);
    return (op == OP_LW) || (op == OP_SW) || (op == OP_RTY) ||
           (op == OP_ORI) || (op == OP_BEQ) || (op == OP_JMP);
  endfunction

endpackage

// File: rtl/mc_next_state.sv
module mc_next_state
  import mc_ctrl_pkg::*;
(
  input  state_e           state_i,
  input  logic [OPC_W-1:0] opcode_i,
  input  logic             ovf_i,
  output state_e           state_o
);

  state_e dispatch;

  always_comb begin
    unique case (opcode_i)
      OP_LW, OP_SW: dispatch = S_ADDR;
      OP_RTY:       dispatch = S_REXE;
      OP_BEQ:       dispatch = S_BEQ;
      OP_JMP:       dispatch = S_JMP;
      OP_ORI:       dispatch = S_ORIEXE;
      default:      dispatch = S_UNDEF;
    endcase
  end

  always_comb begin
    state_o = S_FETCH;
    unique case (state_i)
      S_FETCH:  state_o = S_DECODE;
      S_DECODE: state_o = dispatch;
      S_ADDR:   state_o = (opcode_i == OP_LW) ? S_LDMEM : S_STMEM;
      S_LDMEM:  state_o = S_LDWB;
      S_REXE:   state_o = S_RWB;
      S_RWB:    state_o = ovf_i ? S_OVF : S_FETCH;
      S_ORIEXE: state_o = S_ORIWB;
      S_UNDEF,
      S_OVF:    state_o = S_EPC;
      S_EPC:    state_o = S_VEC;
      default:  state_o = S_FETCH;
    endcase
  end

endmodule

// File: rtl/mc_state_reg.sv
module mc_state_reg
  import mc_ctrl_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  state_e state_d_i,
  output state_e state_q_o
);

  logic [1:0] rst_sync_q;
  logic       rst_sync_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end

  assign rst_sync_n = rst_sync_q[1];

  always_ff @(posedge clk_i or negedge rst_sync_n) begin
    if (!rst_sync_n) state_q_o <= S_FETCH;
    else             state_q_o <= state_d_i;
  end

  AST_FETCH_TO_DECODE: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (state_q_o == S_FETCH) |=> (state_q_o == S_DECODE)); // R2

  AST_EXC_TO_EPC: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (state_q_o == S_UNDEF || state_q_o == S_OVF) |=> (state_q_o == S_EPC)); // R9

  AST_EPC_TO_VEC: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (state_q_o == S_EPC) |=> (state_q_o == S_VEC)); // R10

  AST_VEC_TO_FETCH: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (state_q_o == S_VEC) |=> (state_q_o == S_FETCH)); // R10

endmodule

// File: rtl/mc_ctrl_decode.sv
module mc_ctrl_decode
  import mc_ctrl_pkg::*;
(
  input  state_e state_i,
  output ctrl_t  ctrl_o
);

  always_comb begin
    ctrl_o = '0;
    unique case (state_i)
      S_FETCH: begin
        ctrl_o.pc_we     = 1'b1;
        ctrl_o.ir_we     = 1'b1;
        ctrl_o.mem_rd    = 1'b1;
        ctrl_o.alu_b_sel = B_FOUR;
        ctrl_o.alu_fn    = FN_ADD;
        ctrl_o.pc_sel    = P_ALU;
      end
      S_DECODE: begin
        ctrl_o.tgt_we    = 1'b1;
        ctrl_o.alu_b_sel = B_SEXT2;
        ctrl_o.alu_fn    = FN_ADD;
      end
      S_ADDR: begin
        ctrl_o.alu_a_reg = 1'b1;
        ctrl_o.alu_b_sel = B_SEXT;
      end
      S_LDMEM: begin
        ctrl_o.alu_a_reg     = 1'b1;
        ctrl_o.alu_b_sel     = B_SEXT;
        ctrl_o.mem_rd        = 1'b1;
        ctrl_o.addr_from_alu = 1'b1;
      end
      S_LDWB: begin
        ctrl_o.alu_a_reg   = 1'b1;
        ctrl_o.alu_b_sel   = B_SEXT;
        ctrl_o.rf_we       = 1'b1;
        ctrl_o.rf_from_mem = 1'b1;
      end
      S_STMEM: begin
        ctrl_o.alu_a_reg     = 1'b1;
        ctrl_o.alu_b_sel     = B_SEXT;
        ctrl_o.mem_wr        = 1'b1;
        ctrl_o.addr_from_alu = 1'b1;
      end
      S_REXE: begin
        ctrl_o.alu_a_reg = 1'b1;
        ctrl_o.alu_b_sel = B_RT;
        ctrl_o.alu_fn    = FN_FUN;
      end
      S_RWB: begin
        ctrl_o.alu_a_reg = 1'b1;
        ctrl_o.alu_b_sel = B_RT;
        ctrl_o.alu_fn    = FN_FUN;
        ctrl_o.rf_we     = 1'b1;
        ctrl_o.rf_dst_rd = 1'b1;
      end
      S_BEQ: begin
        ctrl_o.pc_we_cond = 1'b1;
        ctrl_o.alu_a_reg  = 1'b1;
        ctrl_o.alu_b_sel  = B_RT;
        ctrl_o.alu_fn     = FN_SUB;
        ctrl_o.pc_sel     = P_TGT;
      end
      S_JMP: begin
        ctrl_o.pc_we  = 1'b1;
        ctrl_o.pc_sel = P_JMP;
      end
      S_ORIEXE: begin
        ctrl_o.alu_a_reg = 1'b1;
        ctrl_o.alu_b_sel = B_ZEXT;
        ctrl_o.alu_fn    = FN_OR;
      end
      S_ORIWB: begin
        ctrl_o.alu_a_reg = 1'b1;
        ctrl_o.alu_b_sel = B_ZEXT;
        ctrl_o.alu_fn    = FN_OR;
        ctrl_o.rf_we     = 1'b1;
      end
      S_UNDEF: begin
        ctrl_o.cause_we   = 1'b1;
        ctrl_o.cause_code = 1'b0;
      end
      S_OVF: begin
        ctrl_o.cause_we   = 1'b1;
        ctrl_o.cause_code = 1'b1;
      end
      S_EPC: begin
        ctrl_o.epc_we    = 1'b1;
        ctrl_o.alu_b_sel = B_FOUR;
        ctrl_o.alu_fn    = FN_SUB;
      end
      S_VEC: begin
        ctrl_o.pc_we  = 1'b1;
        ctrl_o.pc_sel = P_VEC;
      end
      default: ctrl_o = '0;
    endcase
  end

endmodule

// File: rtl/mc_ctrl_top.sv
module mc_ctrl_top
  import mc_ctrl_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [OPC_W-1:0] opcode_i,
  input  logic             ovf_i,
  output logic             pc_we_o,
  output logic             pc_we_cond_o,
  output logic             ir_we_o,
  output logic             mem_rd_o,
  output logic             mem_wr_o,
  output logic             addr_from_alu_o,
  output logic             rf_we_o,
  output logic             rf_dst_rd_o,
  output logic             rf_from_mem_o,
  output logic             tgt_we_o,
  output logic             alu_a_reg_o,
  output logic [2:0]       alu_b_sel_o,
  output logic [1:0]       alu_fn_o,
  output logic [1:0]       pc_sel_o,
  output logic             cause_we_o,
  output logic             cause_code_o,
  output logic             epc_we_o,
  output logic [3:0]       state_o
);

  state_e state_q;
  state_e state_d;
  ctrl_t  ctrl;

  mc_next_state u_next (
    .state_i  (state_q),
    .opcode_i (opcode_i),
    .ovf_i    (ovf_i),
    .state_o  (state_d)
  );

  mc_state_reg u_sreg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .state_d_i (state_d),
    .state_q_o (state_q)
  );

  mc_ctrl_decode u_dec (
    .state_i (state_q),
    .ctrl_o  (ctrl)
  );

  assign pc_we_o         = ctrl.pc_we;
  assign pc_we_cond_o    = ctrl.pc_we_cond;
  assign ir_we_o         = ctrl.ir_we;
  assign mem_rd_o        = ctrl.mem_rd;
  assign mem_wr_o        = ctrl.mem_wr;
  assign addr_from_alu_o = ctrl.addr_from_alu;
  assign rf_we_o         = ctrl.rf_we;
  assign rf_dst_rd_o     = ctrl.rf_dst_rd;
  assign rf_from_mem_o   = ctrl.rf_from_mem;
  assign tgt_we_o        = ctrl.tgt_we;
  assign alu_a_reg_o     = ctrl.alu_a_reg;
  assign alu_b_sel_o     = ctrl.alu_b_sel;
  assign alu_fn_o        = ctrl.alu_fn;
  assign pc_sel_o        = ctrl.pc_sel;
  assign cause_we_o      = ctrl.cause_we;
  assign cause_code_o    = ctrl.cause_code;
  assign epc_we_o        = ctrl.epc_we;
  assign state_o         = state_q;

  AST_MEM_RW_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_rd_o && mem_wr_o)); // R11

  AST_OVF_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 4'd7 && ovf_i) |=> (cause_we_o && cause_code_o)); // R8

  AST_UNDEF_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 4'd1 && !op_known(opcode_i)) |=> (cause_we_o && !cause_code_o)); // R7

  AST_CAUSE_THEN_EPC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cause_we_o |=> (epc_we_o && alu_fn_o == 2'b01)); // R9

  AST_EPC_THEN_VEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    epc_we_o |=> (pc_we_o && pc_sel_o == 2'b11)); // R10

endmodule

// File: tb/mc_ctrl_top_tb_top.sv
`timescale 1ns/1ps
module mc_ctrl_top_tb_top;

  logic       clk_i = 1'b0;
  logic       rst_ni;
  logic [5:0] opcode_i;
  logic       ovf_i;
  logic pc_we_o, pc_we_cond_o, ir_we_o, mem_rd_o, mem_wr_o, addr_from_alu_o;
  logic rf_we_o, rf_dst_rd_o, rf_from_mem_o, tgt_we_o, alu_a_reg_o;
  logic [2:0] alu_b_sel_o;
  logic [1:0] alu_fn_o, pc_sel_o;
  logic cause_we_o, cause_code_o, epc_we_o;
  logic [3:0] state_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;
  logic [3:0] exp_q[$];

  always #4 clk_i = ~clk_i;

  mc_ctrl_top dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .opcode_i(opcode_i), .ovf_i(ovf_i),
    .pc_we_o(pc_we_o), .pc_we_cond_o(pc_we_cond_o), .ir_we_o(ir_we_o),
    .mem_rd_o(mem_rd_o), .mem_wr_o(mem_wr_o), .addr_from_alu_o(addr_from_alu_o),
    .rf_we_o(rf_we_o), .rf_dst_rd_o(rf_dst_rd_o), .rf_from_mem_o(rf_from_mem_o),
    .tgt_we_o(tgt_we_o), .alu_a_reg_o(alu_a_reg_o), .alu_b_sel_o(alu_b_sel_o),
    .alu_fn_o(alu_fn_o), .pc_sel_o(pc_sel_o), .cause_we_o(cause_we_o),
    .cause_code_o(cause_code_o), .epc_we_o(epc_we_o), .state_o(state_o)
  );

  function automatic logic [20:0] obs_ctrl();
    return {pc_we_o, pc_we_cond_o, ir_we_o, mem_rd_o, mem_wr_o, addr_from_alu_o,
            rf_we_o, rf_dst_rd_o, rf_from_mem_o, tgt_we_o, alu_a_reg_o,
            alu_b_sel_o, alu_fn_o, pc_sel_o, cause_we_o, cause_code_o, epc_we_o};
  endfunction

  // Expected control set per state, taken from the requirements (R2..R11).
  function automatic logic [20:0] exp_ctrl(input logic [3:0] s);
    logic pw = 0, pwc = 0, irw = 0, mr = 0, mw = 0, aa = 0, rw = 0, rd = 0;
    logic rm = 0, tw = 0, ar = 0, cw = 0, cc = 0, ew = 0;
    logic [2:0] bs = 3'b000;
    logic [1:0] fn = 2'b00, ps = 2'b00;
    case (s)
      4'd0:  begin pw = 1; irw = 1; mr = 1; bs = 3'b001; end
      4'd1:  begin tw = 1; bs = 3'b011; end
      4'd2:  begin ar = 1; bs = 3'b010; end
      4'd3:  begin ar = 1; bs = 3'b010; mr = 1; aa = 1; end
      4'd4:  begin ar = 1; bs = 3'b010; rw = 1; rm = 1; end
      4'd5:  begin ar = 1; bs = 3'b010; mw = 1; aa = 1; end
      4'd6:  begin ar = 1; fn = 2'b10; end
      4'd7:  begin ar = 1; fn = 2'b10; rw = 1; rd = 1; end
      4'd8:  begin pwc = 1; ar = 1; fn = 2'b01; ps = 2'b01; end
      4'd9:  begin pw = 1; ps = 2'b10; end
      4'd10: begin ar = 1; bs = 3'b100; fn = 2'b11; end
      4'd11: begin ar = 1; bs = 3'b100; fn = 2'b11; rw = 1; end
      4'd12: begin cw = 1; end
      4'd13: begin cw = 1; cc = 1; end
      4'd14: begin ew = 1; bs = 3'b001; fn = 2'b01; end
      default: begin pw = 1; ps = 2'b11; end
    endcase
    return {pw, pwc, irw, mr, mw, aa, rw, rd, rm, tw, ar, bs, fn, ps, cw, cc, ew};
  endfunction

  function automatic string req_of(input logic [3:0] s);
    case (s)
      4'd0: return "R2";
      4'd1: return "R3";
      4'd2, 4'd3, 4'd4, 4'd5: return "R4";
      4'd6, 4'd7, 4'd10, 4'd11: return "R5";
      4'd8, 4'd9: return "R6";
      4'd12: return "R7";
      4'd13: return "R8";
      4'd14: return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic check_vec(input string req, input logic [20:0] act, input logic [20:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s ctrl act=%b exp=%b", req, act, exp);
    end
  endtask

  task automatic check_st(input string req, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s state act=%0d exp=%0d", req, act, exp);
    end
  endtask

  // Driver: sets the opcode during fetch and pushes the expected state walk.
  task automatic run_instr(input logic [5:0] op, input logic ovf);
    int n = 0;
    logic [3:0] seq[8];
    seq[0] = 4'd0; seq[1] = 4'd1;
    case (op)
      6'b100011: begin seq[2] = 2; seq[3] = 3; seq[4] = 4; n = 5; end
      6'b101011: begin seq[2] = 2; seq[3] = 5; n = 4; end
      6'b000000: begin
        seq[2] = 6; seq[3] = 7; n = 4;
        if (ovf) begin seq[4] = 13; seq[5] = 14; seq[6] = 15; n = 7; end
      end
      6'b000100: begin seq[2] = 8; n = 3; end
      6'b000010: begin seq[2] = 9; n = 3; end
      6'b001011: begin seq[2] = 10; seq[3] = 11; n = 4; end
      default:   begin seq[2] = 12; seq[3] = 14; seq[4] = 15; n = 5; end
    endcase
    opcode_i = op;
    ovf_i    = ovf;
    for (int k = 0; k < n; k++) exp_q.push_back(seq[k]);
    repeat (n) @(posedge clk_i);
    #1;
  endtask

  // Monitor: pops one expected state per cycle and compares state and controls.
  initial begin
    forever begin
      @(negedge clk_i);
      if (exp_q.size() > 0) begin
        logic [3:0] s;
        s = exp_q.pop_front();
        check_st(req_of(s), state_o, s);
        check_vec("R11", obs_ctrl(), exp_ctrl(s));
      end
    end
  end

  initial begin
    rst_ni   = 1'b0;
    opcode_i = 6'b000000;
    ovf_i    = 1'b0;
    repeat (3) @(negedge clk_i);
    check_st("R1", state_o, 4'd0);
    check_vec("R1", obs_ctrl(), exp_ctrl(4'd0));
    rst_ni = 1'b1;
    @(posedge clk_i);
    @(posedge clk_i);
    #1;
    run_instr(6'b100011, 1'b0);  // load: R4
    run_instr(6'b101011, 1'b0);  // store: R4
    run_instr(6'b000000, 1'b0);  // R-type, no overflow: R5, R8
    run_instr(6'b000100, 1'b0);  // branch-equal: R6
    run_instr(6'b000010, 1'b0);  // jump: R6
    run_instr(6'b001011, 1'b0);  // or-immediate: R5
    run_instr(6'b000000, 1'b1);  // R-type overflow: R8, R9, R10
    run_instr(6'b111111, 1'b0);  // undefined: R7
    run_instr(6'b000001, 1'b1);  // undefined, ovf ignored: R7, R8
    run_instr(6'b100011, 1'b1);  // load with ovf ignored: R8
    run_instr(6'b001011, 1'b1);  // or-immediate with ovf ignored: R8
    run_instr(6'b101011, 1'b1);  // store with ovf ignored: R8
    @(negedge clk_i);
    check_st("R2", state_o, 4'd0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog act=running exp=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule